// File: doc/BRIEF.md
# HDLC byte-stuffing framer and deframer

This block sits between a byte-wide sideband link and a message-level client. Its receive half watches the incoming byte stream for the 0x7E flag. It undoes escape sequences and validates the two header bytes. It then hands the payload to the client one byte at a time, marking the first byte and the last byte. The two checksum bytes that close every frame are never delivered. A delay line holds the most recent bytes back until the closing flag shows which of them were checksum and which were payload.

The transmit half takes a payload stream and a peripheral address from the client. It emits the flag, the address byte and the control byte, then the payload, then zero-filled checksum bytes, and finally a closing flag. Any reserved byte value in the address or payload is escaped on the way out.

Each interface uses a one-byte valid/ready handshake. The checksum is a placeholder: it is neither computed nor checked.

Top module: `hdlc_link`

## Requirements
- R1: A well-formed received frame has the form flag 0x7E, address byte, control byte 0x03, payload, two checksum bytes, flag 0x7E. For such a frame the block delivers exactly the payload bytes in order. The sof marker is set on the first delivered byte only and the eof marker on the last only. The checksum bytes are never delivered.
- R2: On receive, 0x7D followed by byte b decodes to b XOR 0x20. Thus 7D 5E yields 7E and 7D 5D yields 7D.
- R3: On receive, if address bit 0 is 0 or the control byte differs from 0x03, the frame is dropped with no payload output and rx_frm_err pulses for one cycle.
- R4: On receive, a frame whose address bits [7:1] differ from the LOCAL_ADDR parameter is dropped silently. It produces no payload and no error.
- R5: A frame closing with fewer than two bytes after the header, or ending right after the address byte, raises rx_frm_err and delivers nothing. A frame with exactly two bytes after the header carries an empty payload and delivers nothing, without error.
- R6: On receive, an escape byte immediately followed by a flag raises rx_frm_err.
- R7: On receive, consecutive flags form empty frames that are dropped with no output and no error. A closing flag also opens the next frame.
- R8: While rx_pl_valid is high and rx_pl_ready is low, the payload outputs hold steady and the link input is not accepted.
- R9: The transmitter emits 7E, {tx_addr,1}, 03, the payload, 00, 00, 7E. The address is sampled when the first payload byte is offered.
- R10: The transmitter sends 7E or 7D in the address or payload as 7D followed by the byte XOR 0x20. So payload 50 50 7E 50 7D 50 goes out as 50 50 7D 5E 50 7D 5D 50.
- R11: With the line always ready, a payload byte is accepted one cycle after the previous one. The exception is a reserved byte, which takes one extra cycle while the escape byte goes out. The first payload byte is accepted on the fourth edge after it is offered.
- R12: While tx_line_valid is high and tx_line_ready is low, the line outputs hold steady.
- R13: After reset both valid outputs are low and the receiver ignores all bytes until it sees a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line_data | input | 8 | Received link byte |
| rx_line_valid | input | 1 | Received link byte present |
| rx_line_ready | output | 1 | Receiver accepts the link byte |
| rx_pl_data | output | 8 | Delivered payload byte |
| rx_pl_valid | output | 1 | Payload byte present |
| rx_pl_sof | output | 1 | First payload byte of a frame |
| rx_pl_eof | output | 1 | Last payload byte of a frame |
| rx_pl_ready | input | 1 | Client accepts the payload byte |
| rx_frm_err | output | 1 | One-cycle framing error pulse |
| tx_pl_data | input | 8 | Payload byte to send |
| tx_pl_valid | input | 1 | Payload byte present |
| tx_pl_last | input | 1 | Payload byte is the last of the frame |
| tx_pl_ready | output | 1 | Transmitter accepts the payload byte |
| tx_addr | input | ADDR_W | Peripheral address for the frame being started |
| tx_line_data | output | 8 | Transmitted link byte |
| tx_line_valid | output | 1 | Link byte present |
| tx_line_ready | input | 1 | Link accepts the byte |

## Verification
The receiver is tried with several byte streams:
- a clean multi-byte frame;
- a frame containing both escape pairs;
- a bad address bit and a bad control byte;
- a foreign address;
- truncated bodies and a header cut short;
- stacked flags;
- an escape before the flag;
- junk ahead of the first flag after reset;
- an empty payload.

Each stream separates a different drop rule: dropped with an error, or dropped silently. The transmitter is driven with the mixed reserved-byte payload, with an address that is itself reserved and with a lone reserved byte. The same runs vary the link ready pattern, so that escape stalls are told apart from backpressure.

// File: rtl/hdlc_pkg.sv
`timescale 1ns/1ps
package hdlc_pkg;
  localparam logic [7:0] FLAG_B = 8'h7E;
  localparam logic [7:0] ESC_B  = 8'h7D;
  localparam logic [7:0] CTRL_B = 8'h03;
  localparam logic [7:0] FLIP_B = 8'h20;

  typedef enum logic [1:0] {RX_HUNT, RX_ADDR, RX_CTRL, RX_BODY} rx_st_t;
  typedef enum logic [2:0] {TX_IDLE, TX_ADDR, TX_CTRL, TX_BODY, TX_CKSUM, TX_CLOSE} tx_st_t;

  function automatic logic is_reserved(input logic [7:0] b);
    return (b == FLAG_B) || (b == ESC_B);
  endfunction
endpackage

// File: rtl/hdlc_rx.sv
`timescale 1ns/1ps
module hdlc_rx import hdlc_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] LOCAL_ADDR = 5,
  parameter int CK_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] ln_data,
  input  logic       ln_valid,
  output logic       ln_ready,
  output logic [7:0] pl_data,
  output logic       pl_valid,
  output logic       pl_sof,
  output logic       pl_eof,
  input  logic       pl_ready,
  output logic       frm_err
);
  localparam int DEPTH = CK_BYTES + 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_st_t        st;
  logic          esc_q;
  logic          first_q;
  logic [CW-1:0] cnt;
  logic [7:0]    sh [DEPTH];

  logic       take, is_flag, esc_start, shift_en;
  logic [7:0] dbyte;

  assign ln_ready  = !pl_valid || pl_ready;
  assign take      = ln_valid && ln_ready;
  assign is_flag   = (ln_data == FLAG_B);
  assign esc_start = !esc_q && (ln_data == ESC_B);
  assign dbyte     = esc_q ? (ln_data ^ FLIP_B) : ln_data;
  assign shift_en  = take && !is_flag && !esc_start && (st == RX_BODY);

  // holding line: newest decoded byte at index 0
  always_ff @(posedge clk) if (shift_en) sh[0] <= dbyte;
  for (genvar i = 1; i < DEPTH; i++) begin : g_dly
    always_ff @(posedge clk) if (shift_en) sh[i] <= sh[i-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= RX_HUNT; esc_q <= 1'b0; first_q <= 1'b0; cnt <= '0;
      pl_valid <= 1'b0; pl_sof <= 1'b0; pl_eof <= 1'b0; pl_data <= '0;
      frm_err <= 1'b0;
    end else begin
      frm_err <= 1'b0;
      if (pl_valid && pl_ready) pl_valid <= 1'b0;
      if (take) begin
        if (is_flag) begin
          esc_q <= 1'b0;
          st    <= RX_ADDR;
          cnt   <= '0;
          if (st != RX_HUNT && esc_q) frm_err <= 1'b1;
          else if (st == RX_CTRL) frm_err <= 1'b1;
          else if (st == RX_BODY) begin
            if (cnt < CW'(CK_BYTES)) frm_err <= 1'b1;
            else if (cnt == CW'(DEPTH)) begin
              pl_valid <= 1'b1; pl_data <= sh[DEPTH-1];
              pl_sof <= first_q; pl_eof <= 1'b1;
            end
          end
        end else if (st != RX_HUNT) begin
          if (esc_start) esc_q <= 1'b1;
          else begin
            esc_q <= 1'b0;
            case (st)
              RX_ADDR: begin
                if (!dbyte[0]) begin frm_err <= 1'b1; st <= RX_HUNT; end
                else if (dbyte[ADDR_W:1] != LOCAL_ADDR) st <= RX_HUNT;
                else st <= RX_CTRL;
              end
              RX_CTRL: begin
                if (dbyte != CTRL_B) begin frm_err <= 1'b1; st <= RX_HUNT; end
                else begin st <= RX_BODY; cnt <= '0; first_q <= 1'b1; end
              end
              RX_BODY: begin
                if (cnt == CW'(DEPTH)) begin
                  pl_valid <= 1'b1; pl_data <= sh[DEPTH-1];
                  pl_sof <= first_q; pl_eof <= 1'b0; first_q <= 1'b0;
                end else cnt <= cnt + 1'b1;
              end
              default: st <= RX_HUNT;
            endcase
          end
        end
      end
    end
  end

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pl_valid && !pl_ready |=> pl_valid && $stable(pl_data) && $stable(pl_sof) && $stable(pl_eof));
  // R8
  rx_block_chk: assert property (@(posedge clk) disable iff (rst)
    pl_valid && !pl_ready |=> $stable(st) && $stable(cnt));
  // R5
  rx_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    frm_err |-> !(pl_valid && pl_eof));
endmodule

// File: rtl/hdlc_tx.sv
`timescale 1ns/1ps
module hdlc_tx import hdlc_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int CK_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        ln_data,
  output logic              ln_valid,
  input  logic              ln_ready
);
  localparam int KW = $clog2(CK_BYTES + 1);

  tx_st_t            st;
  logic              esc_q;
  logic [ADDR_W-1:0] addr_q;
  logic [KW-1:0]     ck_cnt;

  logic [7:0] cur_b;
  logic       cur_avail, cur_esc, need_esc, can_load, step, adv;

  always_comb begin
    cur_b = FLAG_B; cur_avail = 1'b1; cur_esc = 1'b1;
    case (st)
      TX_IDLE:  begin cur_b = FLAG_B; cur_avail = in_valid; cur_esc = 1'b0; end
      TX_ADDR:  cur_b = {addr_q, 1'b1};
      TX_CTRL:  cur_b = CTRL_B;
      TX_BODY:  begin cur_b = in_data; cur_avail = in_valid; end
      TX_CKSUM: cur_b = 8'h00;
      default:  begin cur_b = FLAG_B; cur_esc = 1'b0; end
    endcase
  end

  assign can_load = !ln_valid || ln_ready;
  assign need_esc = cur_esc && is_reserved(cur_b) && !esc_q;
  assign step     = can_load && cur_avail;
  assign adv      = step && !need_esc;
  assign in_ready = (st == TX_BODY) && adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= TX_IDLE; esc_q <= 1'b0; addr_q <= '0; ck_cnt <= '0;
      ln_valid <= 1'b0; ln_data <= '0;
    end else begin
      if (ln_valid && ln_ready) ln_valid <= 1'b0;
      if (step) begin
        ln_valid <= 1'b1;
        ln_data  <= need_esc ? ESC_B : (esc_q ? (cur_b ^ FLIP_B) : cur_b);
        esc_q    <= need_esc;
      end
      if (adv) begin
        case (st)
          TX_IDLE: begin addr_q <= addr; st <= TX_ADDR; end
          TX_ADDR: st <= TX_CTRL;
          TX_CTRL: st <= TX_BODY;
          TX_BODY: if (in_last) begin st <= TX_CKSUM; ck_cnt <= '0; end
          TX_CKSUM: begin
            if (ck_cnt == KW'(CK_BYTES - 1)) st <= TX_CLOSE;
            else ck_cnt <= ck_cnt + 1'b1;
          end
          default: st <= TX_IDLE;
        endcase
      end
    end
  end

  // R12
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ln_valid && !ln_ready |=> ln_valid && $stable(ln_data));
  // R10
  tx_escape_pair_chk: assert property (@(posedge clk) disable iff (rst)
    ln_valid && ln_ready && ln_data == ESC_B |=> ln_valid && !is_reserved(ln_data));
  // R11
  tx_stall_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && is_reserved(in_data) |-> esc_q);
endmodule

// File: rtl/hdlc_link.sv
`timescale 1ns/1ps
module hdlc_link #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] LOCAL_ADDR = 5,
  parameter int CK_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        rx_line_data,
  input  logic              rx_line_valid,
  output logic              rx_line_ready,
  output logic [7:0]        rx_pl_data,
  output logic              rx_pl_valid,
  output logic              rx_pl_sof,
  output logic              rx_pl_eof,
  input  logic              rx_pl_ready,
  output logic              rx_frm_err,
  input  logic [7:0]        tx_pl_data,
  input  logic              tx_pl_valid,
  input  logic              tx_pl_last,
  output logic              tx_pl_ready,
  input  logic [ADDR_W-1:0] tx_addr,
  output logic [7:0]        tx_line_data,
  output logic              tx_line_valid,
  input  logic              tx_line_ready
);
  hdlc_rx #(.ADDR_W(ADDR_W), .LOCAL_ADDR(LOCAL_ADDR), .CK_BYTES(CK_BYTES)) u_rx (
    .clk(clk), .rst(rst),
    .ln_data(rx_line_data), .ln_valid(rx_line_valid), .ln_ready(rx_line_ready),
    .pl_data(rx_pl_data), .pl_valid(rx_pl_valid), .pl_sof(rx_pl_sof),
    .pl_eof(rx_pl_eof), .pl_ready(rx_pl_ready), .frm_err(rx_frm_err)
  );

  hdlc_tx #(.ADDR_W(ADDR_W), .CK_BYTES(CK_BYTES)) u_tx (
    .clk(clk), .rst(rst),
    .in_data(tx_pl_data), .in_valid(tx_pl_valid), .in_last(tx_pl_last),
    .in_ready(tx_pl_ready), .addr(tx_addr),
    .ln_data(tx_line_data), .ln_valid(tx_line_valid), .ln_ready(tx_line_ready)
  );
endmodule

// File: tb/test_hdlc_link.sv
`timescale 1ns/1ps
module test_hdlc_link;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] rx_line_data = '0;
  logic       rx_line_valid = 1'b0;
  logic       rx_line_ready;
  logic [7:0] rx_pl_data;
  logic       rx_pl_valid, rx_pl_sof, rx_pl_eof, rx_frm_err;
  logic       rx_pl_ready = 1'b1;
  logic [7:0] tx_pl_data = '0;
  logic       tx_pl_valid = 1'b0, tx_pl_last = 1'b0;
  logic       tx_pl_ready;
  logic [6:0] tx_addr = 7'h05;
  logic [7:0] tx_line_data;
  logic       tx_line_valid;
  logic       tx_line_ready = 1'b1;

  hdlc_link i_hdlc_link (.*);

  int passes = 0, total = 0;
  bit bp_en = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  // stimulus table: input stream, expected payload, expected error pulses
  localparam int NV = 10;
  localparam logic [7:0] RX_IN [NV][16] = '{
    '{8'h0B,8'h03,8'h11,8'h00,8'h00,8'h7E,8'h7E,8'h0B,8'h03,8'h22,8'h00,8'h00,8'h7E,0,0,0},
    '{8'h7E,8'h0B,8'h03,8'h11,8'h22,8'h33,8'hAA,8'hBB,8'h7E,0,0,0,0,0,0,0},
    '{8'h7E,8'h0B,8'h03,8'h50,8'h7D,8'h5E,8'h7D,8'h5D,8'h01,8'h02,8'h7E,0,0,0,0,0},
    '{8'h7E,8'h0A,8'h03,8'h11,8'h00,8'h00,8'h7E,0,0,0,0,0,0,0,0,0},
    '{8'h7E,8'h0B,8'h02,8'h11,8'h00,8'h00,8'h7E,0,0,0,0,0,0,0,0,0},
    '{8'h7E,8'h0D,8'h03,8'h11,8'h00,8'h00,8'h7E,0,0,0,0,0,0,0,0,0},
    '{8'h7E,8'h0B,8'h03,8'h11,8'h7E,0,0,0,0,0,0,0,0,0,0,0},
    '{8'h7E,8'h7E,8'h7E,0,0,0,0,0,0,0,0,0,0,0,0,0},
    '{8'h7E,8'h0B,8'h03,8'h7D,8'h7E,0,0,0,0,0,0,0,0,0,0,0},
    '{8'h7E,8'h0B,8'h03,8'h00,8'h00,8'h7E,0,0,0,0,0,0,0,0,0,0}};
  localparam int RX_LEN [NV] = '{13, 9, 11, 7, 7, 7, 5, 3, 5, 6};
  localparam logic [7:0] RX_EXP [NV][4] = '{
    '{8'h22,0,0,0}, '{8'h11,8'h22,8'h33,0}, '{8'h50,8'h7E,8'h7D,0}, '{0,0,0,0}, '{0,0,0,0},
    '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}, '{0,0,0,0}};
  localparam int RX_NEXP [NV] = '{1, 3, 3, 0, 0, 0, 0, 0, 0, 0};
  localparam int RX_ERR  [NV] = '{0, 0, 0, 1, 1, 0, 1, 0, 1, 0};

  function automatic string rx_tag(input int i);
    case (i)
      0: return "R13"; 1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R3";
      5: return "R4"; 6: return "R5"; 7: return "R7"; 8: return "R6"; default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (ok) passes++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  // ready patterns, driven away from the active edge
  always @(negedge clk) begin
    cyc++;
    rx_pl_ready   = bp_en ? (cyc % 3 != 0) : 1'b1;
    tx_line_ready = bp_en ? (cyc % 4 != 1) : 1'b1;
  end

  // monitors
  logic [7:0] cap [16]; bit capsof [16]; bit capeof [16];
  int ncap = 0, nerr = 0, rstab_fail = 0, tstab_fail = 0;
  logic [7:0] tcap [32]; int ntcap = 0;
  bit rprev_stall = 0, tprev_stall = 0;
  logic [7:0] rprev_d = '0, tprev_d = '0;
  always @(posedge clk) begin
    if (!rst) begin
      if (rprev_stall && !(rx_pl_valid && rx_pl_data == rprev_d)) rstab_fail++;
      if (tprev_stall && !(tx_line_valid && tx_line_data == tprev_d)) tstab_fail++;
      if (rx_pl_valid && rx_pl_ready && ncap < 16) begin
        cap[ncap] = rx_pl_data; capsof[ncap] = rx_pl_sof; capeof[ncap] = rx_pl_eof; ncap++;
      end
      if (rx_frm_err) nerr++;
      if (tx_line_valid && tx_line_ready && ntcap < 32) begin tcap[ntcap] = tx_line_data; ntcap++; end
      rprev_stall = rx_pl_valid && !rx_pl_ready; rprev_d = rx_pl_data;
      tprev_stall = tx_line_valid && !tx_line_ready; tprev_d = tx_line_data;
    end
  end

  task automatic send_rx(input int i);
    for (int k = 0; k < RX_LEN[i]; k++) begin
      @(negedge clk);
      rx_line_valid = 1'b1; rx_line_data = RX_IN[i][k];
      do @(posedge clk); while (!rx_line_ready);
    end
    @(negedge clk); rx_line_valid = 1'b0;
  endtask

  int waits [8];
  task automatic send_tx(input logic [7:0] p [8], input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tx_pl_valid = 1'b1; tx_pl_data = p[k]; tx_pl_last = (k == n - 1);
      waits[k] = 0;
      do begin @(posedge clk); waits[k]++; end while (!tx_pl_ready);
    end
    @(negedge clk); tx_pl_valid = 1'b0; tx_pl_last = 1'b0;
    repeat (16) @(negedge clk);
  endtask

  task automatic check_tx(input string req, input logic [7:0] e [16], input int n);
    bit ok = (ntcap == n);
    int bad = -1;
    for (int k = 0; k < n && ok; k++) if (tcap[k] != e[k]) begin ok = 0; bad = k; end
    if (bad >= 0) check(ok, req, $sformatf("line byte %0d", bad), tcap[bad], e[bad]);
    else check(ok, req, "line byte count", ntcap, n);
  endtask

  initial begin
    logic [7:0] p0 [8] = '{8'h50,8'h50,8'h7E,8'h50,8'h7D,8'h50,0,0};
    logic [7:0] e0 [16] = '{8'h7E,8'h0B,8'h03,8'h50,8'h50,8'h7D,8'h5E,8'h50,8'h7D,8'h5D,8'h50,8'h00,8'h00,8'h7E,0,0};
    logic [7:0] p1 [8] = '{8'hA5,0,0,0,0,0,0,0};
    logic [7:0] e1 [16] = '{8'h7E,8'h7D,8'h5D,8'h03,8'hA5,8'h00,8'h00,8'h7E,0,0,0,0,0,0,0,0};
    logic [7:0] p2 [8] = '{8'h7E,0,0,0,0,0,0,0};
    logic [7:0] e2 [16] = '{8'h7E,8'h0B,8'h03,8'h7D,8'h5E,8'h00,8'h00,8'h7E,0,0,0,0,0,0,0,0};
    int ew [6] = '{4, 1, 2, 1, 2, 1};

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(!rx_pl_valid, "R13", "rx_pl_valid after reset", rx_pl_valid, 0);
    check(!tx_line_valid, "R13", "tx_line_valid after reset", tx_line_valid, 0);
    check(!rx_frm_err && rx_line_ready, "R13", "err/ready after reset", {rx_frm_err, rx_line_ready}, 1);

    // receive table, with payload backpressure toggling (R8)
    bp_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      bit ok;
      ncap = 0; nerr = 0;
      send_rx(i);
      repeat (12) @(negedge clk);
      ok = (ncap == RX_NEXP[i]);
      for (int k = 0; k < RX_NEXP[i] && ok; k++)
        ok = (cap[k] == RX_EXP[i][k]) && (capsof[k] == (k == 0)) && (capeof[k] == (k == RX_NEXP[i] - 1));
      check(ok, rx_tag(i), $sformatf("vector %0d payload count/bytes/markers", i), ncap, RX_NEXP[i]);
      check(nerr == RX_ERR[i], rx_tag(i), $sformatf("vector %0d error pulses", i), nerr, RX_ERR[i]);
    end
    check(rstab_fail == 0, "R8", "payload hold violations", rstab_fail, 0);

    // transmit: ready always high, escape stall timing
    bp_en = 1'b0;
    repeat (2) @(negedge clk);
    ntcap = 0; tx_addr = 7'h05;
    send_tx(p0, 6);
    check_tx("R9", e0, 14);
    for (int k = 0; k < 6; k++)
      check(waits[k] == ew[k], "R11", $sformatf("accept wait byte %0d", k), waits[k], ew[k]);

    // transmit with line backpressure
    bp_en = 1'b1;
    ntcap = 0;
    send_tx(p0, 6);
    check_tx("R10", e0, 14);
    ntcap = 0; tx_addr = 7'h3E;
    send_tx(p1, 1);
    check_tx("R10", e1, 8);
    ntcap = 0; tx_addr = 7'h05;
    send_tx(p2, 1);
    check_tx("R10", e2, 8);
    check(tstab_fail == 0, "R12", "line hold violations", tstab_fail, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", passes, total);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passes, total);
      $finish;
    end
  end
endmodule